// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised register (eight bits by default) that holds, shifts toward the high end, shifts toward the low end, or takes a parallel word. A two-bit mode input picks the operation, and the register acts on it at each rising clock edge. A single bidirectional bus carries the parallel word in both directions. In normal operation the register drives its contents onto this bus through tri-state drivers. When load mode is selected, those drivers switch off so that an external source can drive the word that will be captured.

Two active-low enables can also release the bus. Releasing it has no effect on the register, which keeps shifting, holding, loading and clearing as usual. The lowest and highest stages are each wired to their own output pin. These two pins are always driven, so a longer word can be built by chaining several blocks through their serial pins. An active-low reset clears the register at once, with no clock needed.

Top module: `usr_shift_reg`

## Requirements
- R1: While rst_n is low, every register bit is 0 right away. This holds whatever the clock and mode inputs are doing, and the register stays 0 until a rising edge comes after rst_n has returned high.
- R2: mode = 2'b00 (hold): the register value does not change across a rising clock edge.
- R3: mode = 2'b01 (shift toward the high end): at the edge, bit 0 takes ser_up_in and every bit i+1 takes the old bit i.
- R4: mode = 2'b10 (shift toward the low end): at the edge, bit W-1 takes ser_dn_in and every bit i takes the old bit i+1.
- R5: mode = 2'b11 (load): at the edge, the register takes the value present on pbus.
- R6: When oe_a_n and oe_b_n are both 0 and mode is not 2'b11, pbus shows the register value.
- R7: When oe_a_n or oe_b_n is 1, the block leaves pbus undriven (high impedance).
- R8: When mode is 2'b11, the block leaves pbus undriven whatever the enables are.
- R9: Operations carried out while the bus is released give the same register contents as they would with the bus enabled.
- R10: lsb_out always equals bit 0 and msb_out always equals bit W-1, whatever the enables and mode are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| oe_a_n | input | 1 | Bus drive enable, active low |
| oe_b_n | input | 1 | Second bus drive enable, active low |
| ser_up_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_dn_in | input | 1 | Serial bit entering bit W-1 on a downward shift |
| pbus | inout | W | Shared parallel bus: register out, or load data in |
| lsb_out | output | 1 | Bit 0, always driven |
| msb_out | output | 1 | Bit W-1, always driven |

## Verification
The next-state assertions assume that mode, the serial inputs and pbus are steady around each rising edge. They also assume that pbus carries a defined value whenever load mode is selected. The bench changes every input only at the falling edge. It drives pbus only while mode is 2'b11, so the bus never has two drivers and a load never captures an undriven bus. Reset is raised and dropped away from the rising edge, so the asynchronous clear can be seen before any clock arrives.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHUP = 2'b01,
    MODE_SHDN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       oe_a_n_i,
  input  logic       oe_b_n_i,
  output usr_mode_e  sel_o,
  output logic       drive_en_o
);
  assign sel_o      = usr_mode_e'(mode_i);
  assign drive_en_o = ~oe_a_n_i & ~oe_b_n_i & (sel_o != MODE_LOAD);

  always_comb begin
    if (oe_a_n_i | oe_b_n_i) p_enable_off_r7: assert (!drive_en_o);
  end
endmodule

// File: rtl/usr_stage_array.sv
module usr_stage_array
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  usr_mode_e    sel_i,
  input  logic         ser_up_i,
  input  logic         ser_dn_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] q_o
);
  localparam int TOP = W - 1;

  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lo
      assign from_below = ser_up_i;
    end else begin : g_lo
      assign from_below = q_o[i-1];
    end
    if (i == TOP) begin : g_hi
      assign from_above = ser_dn_i;
    end else begin : g_hi
      assign from_above = q_o[i+1];
    end

    always_comb begin
      unique case (sel_i)
        MODE_HOLD: nxt[i] = q_o[i];
        MODE_SHUP: nxt[i] = from_below;
        MODE_SHDN: nxt[i] = from_above;
        MODE_LOAD: nxt[i] = par_i[i];
        default:   nxt[i] = q_o[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) p_clear_r1: assert (q_o == '0);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == MODE_HOLD) |=> (q_o == $past(q_o)));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == MODE_SHUP) |=> (q_o == {$past(q_o[W-2:0]), $past(ser_up_i)}));

  p_shift_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == MODE_SHDN) |=> (q_o == {$past(ser_dn_i), $past(q_o[W-1:1])}));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == MODE_LOAD) |=> (q_o == $past(par_i)));
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         ser_up_in,
  input  logic         ser_dn_in,
  inout  wire  [W-1:0] pbus,
  output logic         lsb_out,
  output logic         msb_out
);
  localparam int TOP = W - 1;

  usr_mode_e    sel;
  logic         drive_en;
  logic [W-1:0] q;

  usr_mode_dec u_dec (
    .mode_i     (mode),
    .oe_a_n_i   (oe_a_n),
    .oe_b_n_i   (oe_b_n),
    .sel_o      (sel),
    .drive_en_o (drive_en)
  );

  usr_stage_array #(.W(W)) u_stages (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel),
    .ser_up_i (ser_up_in),
    .ser_dn_i (ser_dn_in),
    .par_i    (pbus),
    .q_o      (q)
  );

  assign pbus    = drive_en ? q : {W{1'bz}};
  assign lsb_out = q[0];
  assign msb_out = q[TOP];

  p_load_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !drive_en);

  p_drive_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a_n && !oe_b_n && mode != 2'b11) |-> drive_en);
endmodule

// File: tb/usr_shift_reg_test.sv
module usr_shift_reg_test;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         oe_a_n = 1'b0;
  logic         oe_b_n = 1'b0;
  logic         ser_up_in = 1'b0;
  logic         ser_dn_in = 1'b0;
  logic [W-1:0] tb_drv = '0;
  wire  [W-1:0] pbus;
  logic         lsb_out, msb_out;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q = '0;

  assign pbus = (mode == 2'b11) ? tb_drv : {W{1'bz}};

  usr_shift_reg #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_up_in(ser_up_in), .ser_dn_in(ser_dn_in), .pbus(pbus),
    .lsb_out(lsb_out), .msb_out(msb_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic [1:0] m,
                                              logic su, logic sd, logic [W-1:0] bus);
    case (m)
      2'b01:   return {cur[W-2:0], su};
      2'b10:   return {sd, cur[W-1:1]};
      2'b11:   return bus;
      default: return cur;
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " R10 lsb"}, {{(W-1){1'b0}}, lsb_out}, {{(W-1){1'b0}}, exp_q[0]});
    chk({req, " R10 msb"}, {{(W-1){1'b0}}, msb_out}, {{(W-1){1'b0}}, exp_q[W-1]});
    if (mode == 2'b11)            chk({req, " R8 bus released"}, pbus, tb_drv);
    else if (oe_a_n || oe_b_n)    chk({req, " R7 bus released"}, pbus, {W{1'bz}});
    else                          chk({req, " R6 bus shows reg"}, pbus, exp_q);
  endtask

  // inputs already set at a falling edge; advance one rising edge, check at next fall
  task automatic step(string req);
    @(posedge clk);
    if (rst_n) exp_q = model_next(exp_q, mode, ser_up_in, ser_dn_in, tb_drv);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic set_in(logic [1:0] m, logic a, logic b, logic su, logic sd, logic [W-1:0] d);
    mode = m; oe_a_n = a; oe_b_n = b; ser_up_in = su; ser_dn_in = sd; tb_drv = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1 reset state");
    rst_n = 1'b1;

    // R5 load, then R6 readback
    set_in(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5); step("R5 load A5");
    set_in(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); step("R2 hold");
    step("R2 hold again");
    set_in(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00); step("R3 shift up in 1");
    set_in(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00); step("R3 shift up in 0");
    set_in(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00); step("R4 shift down in 1");
    set_in(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00); step("R4 shift down in 0");
    // R9: operate with bus released, then enable and compare
    set_in(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00); step("R9 shift up oe_a high");
    set_in(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00); step("R9 shift down oe_b high");
    set_in(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C); step("R9 load with oe high");
    set_in(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    #1 chk("R9 contents after release", pbus, exp_q);
    // R8: load selected with enables low leaves bus to the bench
    set_in(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0);
    #1 chk("R8 load mode releases bus", pbus, 8'hF0);
    step("R5 load F0");
    // R1: asynchronous clear away from the edge
    set_in(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    #(CLK_PERIOD/4) rst_n = 1'b0; exp_q = '0;
    #1 chk("R1 async clear bus", pbus, '0);
    chk("R1 async clear msb", {{(W-1){1'b0}}, msb_out}, '0);
    set_in(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    step("R1 clock ignored in reset");
    rst_n = 1'b1;
    step("R1 first edge after release");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(3));
      set_in(m, ($urandom_range(3) == 0), ($urandom_range(3) == 0),
             1'($urandom), 1'($urandom), W'($urandom));
      case (m)
        2'b00:   step("R2 random");
        2'b01:   step("R3 random");
        2'b10:   step("R4 random");
        default: step("R5 random");
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule